// File: doc/BRIEF.md
# ITU-656 Video Output Formatter

The formatter turns a stream of pixel slots (8-bit Y, Cb and Cr components plus horizontal-blank, vertical-blank, field and frame-start flags) into an 8-bit byte stream with a byte enable, in the style of an ITU-R BT.656 link. Every line starts with an end-of-active-video code placed at the start of its horizontal blanking. A start-of-active-video code sits in the last bytes of the blanking. Both codes are the preamble 0xFF, 0x00, 0x00 followed by a flag byte. Between the two codes come fill bytes, and after the start code come the active bytes.

The upstream source delivers one pixel slot every second clock. In 4:2:2 mode each slot becomes two bytes and the enable is high on every clock. The chroma byte of even pixels carries Cb and that of odd pixels carries Cr. A luminance-only 4:0:0 mode sends one Y byte per slot, so bytes and enables come at half that rate. Active data bytes are kept clear of the reserved values 0x00 and 0xFF. Every output byte can also be emitted bit-reversed. The block holds the incoming slots in a four-slot lookahead line, so that it can place the start code ahead of the first active pixel.

The format, component order and reversal controls are static inputs. They are sampled only when the first slot of a frame is encoded.

Top module: `vid656_formatter`

## Requirements
- R1: While reset is asserted, and until the fifth slot strobe after reset, `vid_en` stays low. Slots are held in a four-slot lookahead.
- R2: The first bytes of each horizontal blanking interval are 0xFF, 0x00, 0x00, XY with H=1. The four bytes right before the first active byte of the line are 0xFF, 0x00, 0x00, XY with H=0. The total byte count equals the sum over slots of 2 (4:2:2) or 1 (4:0:0).
- R3: The flag byte XY is {1, F, V, H, V^H, F^H, F^V, F^V^H} from bit 7 down to bit 0. F and V are taken from the slot's field and vertical-blank flags.
- R4: In 4:2:2 active video, each slot gives a chroma byte and a luma byte. The chroma byte is Cb for even pixels and Cr for odd pixels, counted from 0 at the first active pixel of the line. `cfg_cbcr_swap`=1 exchanges the two. `cfg_luma_first`=1 puts the luma byte before the chroma byte.
- R5: With `cfg_mono`=1 (4:0:0), each slot gives the single byte Y and `vid_en` pulses on every second clock. In 4:2:2, `vid_en` is high on every clock while slots arrive.
- R6: An active data byte of 0x00 is sent as 0x01, and one of 0xFF is sent as 0xFE.
- R7: With `cfg_bit_rev`=1, every output byte is sent with bit i moved to bit 7-i. This covers timing codes, fill and data, and is applied after R6.
- R8: Horizontal blanking bytes that are not timing codes are 0x80 and 0x10 alternately in 4:2:2 (0x80 first), and 0x10 in 4:0:0.
- R9: In the active part of a vertically blanked line, chroma positions carry 0x80 and luma positions carry 0x10. In 4:0:0 every such byte is 0x10.
- R10: The configuration inputs are sampled only when the slot that carries `pix_frame` is encoded. Changes at other times have no effect on the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_stb | input | 1 | One pixel slot is presented this cycle |
| pix_hblank | input | 1 | Slot lies in horizontal blanking |
| pix_vblank | input | 1 | Slot belongs to a vertically blanked line |
| pix_field | input | 1 | Field flag of the slot |
| pix_frame | input | 1 | First slot of a frame |
| pix_y | input | 8 | Luma component |
| pix_cb | input | 8 | Blue-difference component |
| pix_cr | input | 8 | Red-difference component |
| cfg_mono | input | 1 | 1 selects 4:0:0 luminance-only output |
| cfg_cbcr_swap | input | 1 | 1 exchanges Cb and Cr positions |
| cfg_luma_first | input | 1 | 1 sends luma ahead of chroma |
| cfg_bit_rev | input | 1 | 1 reverses the bit order of every byte |
| vid_byte | output | 8 | Output byte |
| vid_en | output | 1 | Byte enable / pixel clock enable |

## Verification
The assertions take several things for granted about the input. `pix_stb` never rises on two adjacent clocks. Horizontal blanking spans at least four slots in 4:2:2 and eight in 4:0:0, so the two timing codes of a line never overlap. Field and vertical-blank flags stay constant across a line, and a frame begins on the first blanking slot of a line. The bench feeds slots at exactly every second clock and uses ten-slot blanking and eight-pixel lines. It raises the frame flag only on a line's first blanking slot. It toggles the configuration inputs mid-frame only inside a window that closes well before the next frame slot reaches the encoder.

// File: rtl/itu656_pkg.sv
package itu656_pkg;

    localparam int BYTE_W  = 8;
    localparam int PRE_LEN = 4;           // bytes in a timing reference
    localparam int LOOK    = PRE_LEN;     // lookahead slots needed in 4:0:0

    localparam logic [BYTE_W-1:0] FILL_CHROMA = 8'h80;
    localparam logic [BYTE_W-1:0] FILL_LUMA   = 8'h10;

    typedef struct packed {
        logic              valid;
        logic              hblank;
        logic              vblank;
        logic              field;
        logic              frame;
        logic [BYTE_W-1:0] y;
        logic [BYTE_W-1:0] cb;
        logic [BYTE_W-1:0] cr;
    } slot_t;

    typedef struct packed {
        logic mono;
        logic cbcr_swap;
        logic luma_first;
        logic bit_rev;
    } cfg_t;

    // Keep reserved sync values out of active data.
    function automatic logic [BYTE_W-1:0] clip_data(input logic [BYTE_W-1:0] b);
        if (b == 8'h00)      return 8'h01;
        else if (b == 8'hFF) return 8'hFE;
        else                 return b;
    endfunction

    function automatic logic [BYTE_W-1:0] rev_byte(input logic [BYTE_W-1:0] b);
        logic [BYTE_W-1:0] r;
        for (int i = 0; i < BYTE_W; i++) r[i] = b[BYTE_W-1-i];
        return r;
    endfunction

    function automatic logic [BYTE_W-1:0] xy_word(input logic f, input logic v, input logic h);
        return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h};
    endfunction

    function automatic logic [BYTE_W-1:0] preamble_byte(input logic [1:0] k,
                                                        input logic [BYTE_W-1:0] xy);
        case (k)
            2'd0:    return 8'hFF;
            2'd1:    return 8'h00;
            2'd2:    return 8'h00;
            default: return xy;
        endcase
    endfunction

endpackage

// File: rtl/fmt_slot_delay.sv
module fmt_slot_delay
    import itu656_pkg::*;
#(
    parameter int DEPTH = LOOK
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shift,
    input  slot_t            slot_in,
    output slot_t            head,
    output logic [DEPTH-2:0] look_act
);

    slot_t stage_q [DEPTH];
    slot_t stage_d [DEPTH];

    for (genvar k = 0; k < DEPTH; k++) begin : g_stage
        always_comb begin
            stage_d[k] = stage_q[k];
            if (shift) begin
                if (k == 0) stage_d[k] = slot_in;
                else        stage_d[k] = stage_q[(k == 0) ? 0 : k-1];
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[k] <= '0;
            else        stage_q[k] <= stage_d[k];
        end
    end

    // look_act[0] is the slot directly behind the head.
    for (genvar j = 0; j < DEPTH-1; j++) begin : g_look
        assign look_act[j] = stage_q[DEPTH-2-j].valid && !stage_q[DEPTH-2-j].hblank;
    end

    assign head = stage_q[DEPTH-1];

endmodule

// File: rtl/fmt_slot_encoder.sv
module fmt_slot_encoder
    import itu656_pkg::*;
#(
    parameter int CNT_W = $clog2(LOOK) + 1
) (
    input  logic              mono,
    input  logic              cbcr_swap,
    input  logic              luma_first,
    input  logic              hblank,
    input  logic              vblank,
    input  logic              field,
    input  logic [BYTE_W-1:0] y,
    input  logic [BYTE_W-1:0] cb,
    input  logic [BYTE_W-1:0] cr,
    input  logic [CNT_W-1:0]  blank_cnt,
    input  logic              parity,
    input  logic [LOOK-1:0]   ahead_act,
    output logic [BYTE_W-1:0] byte0,
    output logic [BYTE_W-1:0] byte1,
    output logic              code0,
    output logic              code1,
    output logic              two_bytes
);

    localparam logic [CNT_W-1:0] EAV_MONO = CNT_W'(PRE_LEN);
    localparam logic [CNT_W-1:0] EAV_DUAL = CNT_W'(PRE_LEN / 2);

    logic [BYTE_W-1:0] xy_eav, xy_sav, chroma, luma;

    always_comb begin
        xy_eav = xy_word(field, vblank, 1'b1);
        xy_sav = xy_word(field, vblank, 1'b0);
        chroma = vblank ? FILL_CHROMA : clip_data((parity ^ cbcr_swap) ? cr : cb);
        luma   = vblank ? FILL_LUMA   : clip_data(y);
    end

    always_comb begin
        byte0     = FILL_LUMA;
        byte1     = FILL_LUMA;
        code0     = 1'b0;
        code1     = 1'b0;
        two_bytes = !mono;
        if (mono) begin
            if (hblank) begin
                if (blank_cnt < EAV_MONO) begin
                    byte0 = preamble_byte(blank_cnt[1:0], xy_eav);
                    code0 = 1'b1;
                end else begin
                    byte0 = FILL_LUMA;
                    for (int i = LOOK-1; i >= 0; i--) begin
                        if (ahead_act[i]) begin
                            byte0 = preamble_byte(2'(PRE_LEN-1-i), xy_sav);
                            code0 = 1'b1;
                        end
                    end
                end
            end else begin
                byte0 = luma;
            end
        end else begin
            if (hblank) begin
                if (blank_cnt < EAV_DUAL) begin
                    byte0 = preamble_byte({blank_cnt[0], 1'b0}, xy_eav);
                    byte1 = preamble_byte({blank_cnt[0], 1'b1}, xy_eav);
                    code0 = 1'b1;
                    code1 = 1'b1;
                end else begin
                    byte0 = FILL_CHROMA;
                    byte1 = FILL_LUMA;
                    for (int i = 1; i >= 0; i--) begin
                        if (ahead_act[i]) begin
                            byte0 = preamble_byte({i == 0, 1'b0}, xy_sav);
                            byte1 = preamble_byte({i == 0, 1'b1}, xy_sav);
                            code0 = 1'b1;
                            code1 = 1'b1;
                        end
                    end
                end
            end else if (luma_first) begin
                byte0 = luma;
                byte1 = chroma;
            end else begin
                byte0 = chroma;
                byte1 = luma;
            end
        end
    end

endmodule

// File: rtl/fmt_byte_serializer.sv
module fmt_byte_serializer
    import itu656_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    input  logic              two_bytes,
    input  logic              bit_rev,
    input  logic [BYTE_W-1:0] byte0,
    input  logic [BYTE_W-1:0] byte1,
    output logic [BYTE_W-1:0] vid_byte,
    output logic              vid_en
);

    typedef struct packed {
        logic [BYTE_W-1:0] out_byte;
        logic              out_en;
        logic [BYTE_W-1:0] pend;
        logic              pend_v;
    } ser_t;

    ser_t ser_d, ser_q;

    always_comb begin
        ser_d        = ser_q;
        ser_d.out_en = 1'b0;
        if (take) begin
            ser_d.out_byte = bit_rev ? rev_byte(byte0) : byte0;
            ser_d.out_en   = 1'b1;
            ser_d.pend     = bit_rev ? rev_byte(byte1) : byte1;
            ser_d.pend_v   = two_bytes;
        end else if (ser_q.pend_v) begin
            ser_d.out_byte = ser_q.pend;
            ser_d.out_en   = 1'b1;
            ser_d.pend_v   = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ser_q <= '0;
        else        ser_q <= ser_d;
    end

    assign vid_byte = ser_q.out_byte;
    assign vid_en   = ser_q.out_en;

endmodule

// File: rtl/vid656_formatter.sv
module vid656_formatter
    import itu656_pkg::*;
#(
    parameter int DEPTH = LOOK,
    parameter int CNT_W = $clog2(DEPTH) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pix_stb,
    input  logic              pix_hblank,
    input  logic              pix_vblank,
    input  logic              pix_field,
    input  logic              pix_frame,
    input  logic [BYTE_W-1:0] pix_y,
    input  logic [BYTE_W-1:0] pix_cb,
    input  logic [BYTE_W-1:0] pix_cr,
    input  logic              cfg_mono,
    input  logic              cfg_cbcr_swap,
    input  logic              cfg_luma_first,
    input  logic              cfg_bit_rev,
    output logic [BYTE_W-1:0] vid_byte,
    output logic              vid_en
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        cfg_t             cfg;
        logic [CNT_W-1:0] blank_cnt;
        logic             parity;
    } seq_t;

    seq_t  seq_d, seq_q;
    slot_t slot_in, head;
    cfg_t  cfg_in, cfg_eff;

    logic [DEPTH-2:0]  look_act;
    logic [DEPTH-1:0]  ahead_act;
    logic              take;
    logic [BYTE_W-1:0] enc_b0, enc_b1;
    logic              enc_code0, enc_code1, enc_two;
    logic              cfg_mono_q, cfg_rev_q;

    always_comb begin
        slot_in.valid  = pix_stb;
        slot_in.hblank = pix_hblank;
        slot_in.vblank = pix_vblank;
        slot_in.field  = pix_field;
        slot_in.frame  = pix_frame;
        slot_in.y      = pix_y;
        slot_in.cb     = pix_cb;
        slot_in.cr     = pix_cr;
        cfg_in.mono       = cfg_mono;
        cfg_in.cbcr_swap  = cfg_cbcr_swap;
        cfg_in.luma_first = cfg_luma_first;
        cfg_in.bit_rev    = cfg_bit_rev;
    end

    fmt_slot_delay #(.DEPTH(DEPTH)) u_delay (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift    (pix_stb),
        .slot_in  (slot_in),
        .head     (head),
        .look_act (look_act)
    );

    assign ahead_act = {pix_stb && !pix_hblank, look_act};
    assign take      = pix_stb && head.valid;
    assign cfg_eff   = head.frame ? cfg_in : seq_q.cfg;

    fmt_slot_encoder #(.CNT_W(CNT_W)) u_enc (
        .mono       (cfg_eff.mono),
        .cbcr_swap  (cfg_eff.cbcr_swap),
        .luma_first (cfg_eff.luma_first),
        .hblank     (head.hblank),
        .vblank     (head.vblank),
        .field      (head.field),
        .y          (head.y),
        .cb         (head.cb),
        .cr         (head.cr),
        .blank_cnt  (seq_q.blank_cnt),
        .parity     (seq_q.parity),
        .ahead_act  (ahead_act),
        .byte0      (enc_b0),
        .byte1      (enc_b1),
        .code0      (enc_code0),
        .code1      (enc_code1),
        .two_bytes  (enc_two)
    );

    always_comb begin
        seq_d = seq_q;
        if (take) begin
            seq_d.cfg = cfg_eff;
            if (head.hblank) begin
                seq_d.parity = 1'b0;
                if (seq_q.blank_cnt != CNT_MAX) seq_d.blank_cnt = seq_q.blank_cnt + 1'b1;
            end else begin
                seq_d.parity    = ~seq_q.parity;
                seq_d.blank_cnt = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '0;
        else        seq_q <= seq_d;
    end

    fmt_byte_serializer u_ser (
        .clk       (clk),
        .rst_n     (rst_n),
        .take      (take),
        .two_bytes (enc_two),
        .bit_rev   (cfg_eff.bit_rev),
        .byte0     (enc_b0),
        .byte1     (enc_b1),
        .vid_byte  (vid_byte),
        .vid_en    (vid_en)
    );

    assign cfg_mono_q = seq_q.cfg.mono;
    assign cfg_rev_q  = seq_q.cfg.bit_rev;

endmodule

// File: rtl/vid656_formatter_chk.sv
module vid656_formatter_chk
    import itu656_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [BYTE_W-1:0] vid_byte,
    input logic              vid_en,
    input logic              cfg_mono_q,
    input logic              cfg_rev_q,
    input logic              take,
    input logic [BYTE_W-1:0] enc_b0,
    input logic [BYTE_W-1:0] enc_b1,
    input logic              enc_code0,
    input logic              enc_code1,
    input logic              enc_two
);

    logic [BYTE_W-1:0] h1, h2, h3, xy_seen;
    logic [1:0]        hcnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            h1 <= '0; h2 <= '0; h3 <= '0; hcnt <= '0;
        end else if (vid_en) begin
            h1 <= vid_byte; h2 <= h1; h3 <= h2;
            if (hcnt != 2'd3) hcnt <= hcnt + 2'd1;
        end
    end

    assign xy_seen = cfg_rev_q ? rev_byte(vid_byte) : vid_byte;

    // R1
    reset_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !vid_en);

    // R2
    preamble_second_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vid_en && hcnt != 2'd0 && h1 == 8'hFF) |-> vid_byte == 8'h00);

    // R2
    preamble_third_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vid_en && hcnt >= 2'd2 && h2 == 8'hFF && h1 == 8'h00) |-> vid_byte == 8'h00);

    // R3
    xy_protect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vid_en && hcnt == 2'd3 && h3 == 8'hFF && h2 == 8'h00 && h1 == 8'h00)
        |-> xy_seen == xy_word(xy_seen[6], xy_seen[5], xy_seen[4]));

    // R6
    clip_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !enc_code0) |-> (enc_b0 != 8'h00 && enc_b0 != 8'hFF));

    // R6
    clip_second_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take && enc_two && !enc_code1) |-> (enc_b1 != 8'h00 && enc_b1 != 8'hFF));

    // R5
    mono_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vid_en && $past(vid_en)) |-> !$past(cfg_mono_q));

endmodule

bind vid656_formatter vid656_formatter_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .vid_byte   (vid_byte),
    .vid_en     (vid_en),
    .cfg_mono_q (cfg_mono_q),
    .cfg_rev_q  (cfg_rev_q),
    .take       (take),
    .enc_b0     (enc_b0),
    .enc_b1     (enc_b1),
    .enc_code0  (enc_code0),
    .enc_code1  (enc_code1),
    .enc_two    (enc_two)
);

// File: tb/vid656_formatter_bench.sv
module vid656_formatter_bench;

    localparam int HB    = 10;          // blanking slots per line
    localparam int AW    = 8;           // active pixels per line
    localparam int SPL   = HB + AW;
    localparam int LPF   = 3;           // line 0 is vertically blanked
    localparam int SPF   = SPL * LPF;
    localparam int NFR   = 16;          // one frame per configuration
    localparam int NSLOT = SPF * NFR;
    localparam int MAXB  = 2 * NSLOT;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       pix_stb, pix_hblank, pix_vblank, pix_field, pix_frame;
    logic [7:0] pix_y, pix_cb, pix_cr;
    logic       cfg_mono, cfg_cbcr_swap, cfg_luma_first, cfg_bit_rev;
    logic [7:0] vid_byte;
    logic       vid_en;

    always #4 clk = ~clk;

    vid656_formatter u_vid656_formatter (
        .clk(clk), .rst_n(rst_n), .pix_stb(pix_stb), .pix_hblank(pix_hblank),
        .pix_vblank(pix_vblank), .pix_field(pix_field), .pix_frame(pix_frame),
        .pix_y(pix_y), .pix_cb(pix_cb), .pix_cr(pix_cr),
        .cfg_mono(cfg_mono), .cfg_cbcr_swap(cfg_cbcr_swap),
        .cfg_luma_first(cfg_luma_first), .cfg_bit_rev(cfg_bit_rev),
        .vid_byte(vid_byte), .vid_en(vid_en)
    );

    int    checks = 0, failures = 0, exp_n = 0, rx = 0, cyc = 0, last_cyc = 0;
    bit    done = 1'b0;
    logic [7:0] exp_b [MAXB];
    string      exp_t [MAXB];
    bit         exp_m [MAXB];

    function automatic logic [7:0] rv(input logic [7:0] b);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) r[i] = b[7-i];
        return r;
    endfunction

    function automatic logic [7:0] clp(input logic [7:0] b);
        return (b == 8'h00) ? 8'h01 : (b == 8'hFF) ? 8'hFE : b;
    endfunction

    function automatic logic [7:0] xyb(input bit f, input bit v, input bit h);
        return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h};
    endfunction

    function automatic logic [7:0] val_y(input int fr, input int ln, input int x);
        if (x == 2) return 8'h00;
        if (x == 5) return 8'hFF;
        return 8'((fr * 29 + ln * 71 + x * 13 + 5) % 256);
    endfunction

    function automatic logic [7:0] val_cb(input int fr, input int ln, input int x);
        if (x == 0) return 8'h00;
        if (x == 4) return 8'hFF;
        return 8'((fr * 17 + ln * 5 + x * 41 + 200) % 256);
    endfunction

    function automatic logic [7:0] val_cr(input int fr, input int ln, input int x);
        if (x == 1) return 8'hFF;
        if (x == 6) return 8'h00;
        return 8'((fr * 7 + ln * 93 + x * 19 + 100) % 256);
    endfunction

    function automatic logic [7:0] pre(input int k, input logic [7:0] xy);
        return (k == 0) ? 8'hFF : (k == 3) ? xy : 8'h00;
    endfunction

    function automatic bit garbage_frame(input int fr);
        return (fr % 3) == 1;
    endfunction

    task automatic push(input logic [7:0] b, input string tag, input bit mono,
                        input bit rev, input bit gwin);
        exp_b[exp_n] = rev ? rv(b) : b;
        exp_t[exp_n] = gwin ? "R10" : tag;   // R10: mid-frame cfg changes ignored
        exp_m[exp_n] = mono;
        exp_n++;
    endtask

    task automatic build_expected();
        for (int i = 0; i < NSLOT; i++) begin
            int fr = i / SPF, r = i % SPF, ln = r / SPL, h = r % SPL, x = h - HB;
            bit mono = fr[0], swp = fr[1], lf = fr[2], rev = fr[3];
            bit vb = (ln == 0), f = fr[1] ^ fr[2];
            bit gw = garbage_frame(fr) && r >= 8 && r <= 40;
            string dt = rev ? "R7" : (mono ? "R5" : "R4");
            if (h < HB) begin
                if (mono) begin
                    if (h < 4)           push(pre(h, xyb(f, vb, 1)), h == 3 ? "R3" : "R2", 1, rev, gw);
                    else if (h >= HB-4)  push(pre(h-(HB-4), xyb(f, vb, 0)), h == HB-1 ? "R3" : "R2", 1, rev, gw);
                    else                 push(8'h10, "R8", 1, rev, gw);
                end else begin
                    if (h < 2) begin
                        push(pre(2*h, xyb(f, vb, 1)), "R2", 0, rev, gw);
                        push(pre(2*h+1, xyb(f, vb, 1)), h == 1 ? "R3" : "R2", 0, rev, gw);
                    end else if (h >= HB-2) begin
                        push(pre(2*(h-(HB-2)), xyb(f, vb, 0)), "R2", 0, rev, gw);
                        push(pre(2*(h-(HB-2))+1, xyb(f, vb, 0)), h == HB-1 ? "R3" : "R2", 0, rev, gw);
                    end else begin
                        push(8'h80, "R8", 0, rev, gw);
                        push(8'h10, "R8", 0, rev, gw);
                    end
                end
            end else if (vb) begin
                if (mono)    push(8'h10, "R9", 1, rev, gw);
                else if (lf) begin push(8'h10, "R9", 0, rev, gw); push(8'h80, "R9", 0, rev, gw); end
                else         begin push(8'h80, "R9", 0, rev, gw); push(8'h10, "R9", 0, rev, gw); end
            end else begin
                logic [7:0] yy = val_y(fr, ln, x);
                logic [7:0] cc = ((x % 2 == 0) ^ swp) ? val_cb(fr, ln, x) : val_cr(fr, ln, x);
                string ty = (yy == 8'h00 || yy == 8'hFF) ? "R6" : dt;
                string tc = (cc == 8'h00 || cc == 8'hFF) ? "R6" : dt;
                if (mono)    push(clp(yy), ty, 1, rev, gw);
                else if (lf) begin push(clp(yy), ty, 0, rev, gw); push(clp(cc), tc, 0, rev, gw); end
                else         begin push(clp(cc), tc, 0, rev, gw); push(clp(yy), ty, 0, rev, gw); end
            end
        end
    endtask

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    task automatic feed(input int i, input bit flush);
        int fr = flush ? NFR-1 : i / SPF, r = i % SPF, ln = r / SPL, h = r % SPL, x = h - HB;
        bit gw = !flush && garbage_frame(fr) && r >= 12 && r <= 44;
        @(negedge clk);
        pix_stb    = 1'b1;
        pix_hblank = flush ? 1'b1 : (h < HB);
        pix_vblank = flush ? 1'b0 : (ln == 0);
        pix_field  = fr[1] ^ fr[2];
        pix_frame  = !flush && r == 0;
        pix_y      = (x >= 0) ? val_y(fr, ln, x)  : 8'h00;
        pix_cb     = (x >= 0) ? val_cb(fr, ln, x) : 8'hFF;
        pix_cr     = (x >= 0) ? val_cr(fr, ln, x) : 8'h00;
        if (!flush) begin
            cfg_mono       = fr[0] ^ gw;
            cfg_cbcr_swap  = fr[1] ^ gw;
            cfg_luma_first = fr[2] ^ gw;
            cfg_bit_rev    = fr[3] ^ gw;
        end
        @(negedge clk);
        pix_stb = 1'b0;
    endtask

    always @(posedge clk) cyc++;

    // Output monitor: compare bytes in order (R2..R10) and the enable cadence (R5).
    always @(negedge clk) begin
        if (rst_n && vid_en && !done) begin
            if (rx < exp_n) begin
                check(vid_byte == exp_b[rx], exp_t[rx], vid_byte, exp_b[rx]);
                if (rx > 0 && exp_m[rx] == exp_m[rx-1])
                    check((cyc - last_cyc) == (exp_m[rx] ? 2 : 1), "R5",
                          cyc - last_cyc, exp_m[rx] ? 2 : 1);
            end else begin
                check(1'b0, "R2", rx, exp_n);
            end
            last_cyc = cyc;
            rx++;
        end
    end

    initial begin
        #(8 * 20000);
        if (!done) begin
            done = 1'b1;
            failures++;
            $display("FAIL R2 watchdog expired actual=%0d expected=%0d", rx, exp_n);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; pix_stb = 1'b0; pix_hblank = 1'b1; pix_vblank = 1'b0;
        pix_field = 1'b0; pix_frame = 1'b0; pix_y = '0; pix_cb = '0; pix_cr = '0;
        cfg_mono = 1'b0; cfg_cbcr_swap = 1'b0; cfg_luma_first = 1'b0; cfg_bit_rev = 1'b0;
        build_expected();
        repeat (3) @(negedge clk);
        check(vid_en == 1'b0, "R1", vid_en, 0);     // R1: idle in reset
        rst_n = 1'b1;
        @(negedge clk);
        check(vid_en == 1'b0, "R1", vid_en, 0);
        for (int i = 0; i < 4; i++) feed(i, 1'b0);
        check(rx == 0 && vid_en == 1'b0, "R1", rx, 0);   // R1: lookahead still filling
        for (int i = 4; i < NSLOT; i++) feed(i, 1'b0);
        for (int i = 0; i < 4; i++) feed(i, 1'b1);
        repeat (12) @(negedge clk);
        check(rx == exp_n, "R2", rx, exp_n);            // R2: total byte count
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule